// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns a parallel stereo pair of two's-complement samples into a single serial data line for a downstream serial audio receiver. It is a pure slave. The bit clock, the left/right clock and the optional word clock all arrive from outside. They are sampled in the system clock domain, and the block never drives any of them. The bit clock may pause for any length of time. The left/right clock is assumed to run without interruption.

Samples are written into a holding register with a one-cycle load strobe. At the start of every frame, the holding pair is copied into the pair being sent. When nothing new has been loaded, the last pair goes out again. There are four framing modes, a choice of bit clock polarity, and a word length that can be set anywhere from 4 to 24 bits.

Top module: `audio_ser_tx`

## Requirements
- R1: Each word is sent MSB first. The sample inputs are left-aligned: with an effective length L, bits 23 down to 24-L of the sample appear on consecutive bit slots.
- R2: `word_len` values below 4 act as 4, and values above 24 act as 24. No word is ever longer than 24 bits.
- R3: Mode 0 (`fmt_sel`=0), left-justified: a channel starts at the launching bit clock edge where the sampled `lr_clk` level differs from its level at the previous launching edge. The MSB is driven at that same edge. `lr_clk` low selects the left channel and high selects the right channel.
- R4: Mode 1, left-justified with a one-bit delay: same as mode 0, but the MSB is driven one launching edge after the channel start.
- R5: Mode 2, right-justified with a fixed offset: same as mode 0, but the MSB is driven 16 launching edges after the channel start.
- R6: Mode 3, word-clock triggered: a channel starts at the launching edge where `word_clk` is sampled high after being low at the previous launching edge. The MSB is driven at that edge, and the channel is the `lr_clk` level at that edge. In mode 3, `lr_clk` changes without a word clock rise start nothing. In modes 0 to 2, `word_clk` has no effect.
- R7: With `samp_pol`=0, data changes only on falling bit clock edges, so the receiver samples on rising edges. With `samp_pol`=1 the edges are reversed.
- R8: Outside the L data slots of a channel, and before the first channel start after reset, `sdata_out` is low.
- R9: A frame starts at each left-channel start. At that point the pair most recently loaded with `load` becomes the pair that is sent. If no load occurs, the previous pair is repeated. A load during a frame affects only the following frames.
- R10: Reset drives `sdata_out` low and clears both holding registers to zero.
- R11: The bit clock may stop at either level for any number of system cycles. `sdata_out` holds its value, and bit positions continue when the clock resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | External bit clock, may be gated |
| lr_clk | input | 1 | External left/right clock, low = left |
| word_clk | input | 1 | External word clock, used in mode 3 |
| samp_pol | input | 1 | 0: receiver samples on rising bit clock edges, 1: falling |
| fmt_sel | input | 2 | Framing mode 0..3 |
| word_len | input | 5 | Requested bits per word, clamped to 4..24 |
| load | input | 1 | One-cycle strobe that captures `left_in`/`right_in` |
| left_in | input | 24 | Left sample, left-aligned two's complement |
| right_in | input | 24 | Right sample, left-aligned two's complement |
| sdata_out | output | 1 | Serial data line |

## Verification
Every transition of an external clock passes through two synchronizer flops and one edge register. As a result, `sdata_out` takes its new bit on the third rising `clk` edge after a launching bit clock transition. The bench holds each bit clock phase for four system cycles and compares the line just before it drives the sampling transition, so each bit is checked one cycle after it is due and before it may change again. A load is only observed at the next left-channel start, so the bench assigns a loaded pair to expected values only from the next frame it drives.

// File: rtl/astx_pkg.sv
package astx_pkg;

   typedef enum logic [1:0] {
      FMT_LJ     = 2'd0,
      FMT_LJ_DLY = 2'd1,
      FMT_RJ     = 2'd2,
      FMT_WCK    = 2'd3
   } astx_fmt_e;

   localparam logic CH_LEFT  = 1'b0;
   localparam logic CH_RIGHT = 1'b1;

endpackage

// File: rtl/astx_sync.sv
module astx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic lvl
);

   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("astx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_in};
   end

   assign lvl = sh_q[STAGES-1];

endmodule

// File: rtl/astx_framer.sv
module astx_framer
   import astx_pkg::*;
#(
   parameter int MAX_W  = 24,
   parameter int RJ_OFS = 16,
   localparam int LEN_W = $clog2(MAX_W + 1),
   localparam int IDX_W = $clog2(MAX_W),
   localparam int CNT_W = $clog2(RJ_OFS + MAX_W + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  astx_fmt_e        fmt,
   input  logic             lr_lvl,
   input  logic             wck_lvl,
   input  logic [LEN_W-1:0] len_eff,
   output logic             chan_start,
   output logic             chan_nxt,
   output logic             in_word,
   output logic [IDX_W-1:0] bit_idx
);

   logic [CNT_W-1:0] cnt_q, cnt_n, dly, pos;
   logic             lr_q, wck_q, ch_q, start;

   always_comb begin
      unique case (fmt)
         FMT_LJ_DLY: dly = CNT_W'(1);
         FMT_RJ:     dly = CNT_W'(RJ_OFS);
         default:    dly = '0;
      endcase
      start = (fmt == FMT_WCK) ? (wck_lvl & ~wck_q) : (lr_lvl ^ lr_q);
      if (start)       cnt_n = '0;
      else if (&cnt_q) cnt_n = cnt_q;
      else             cnt_n = cnt_q + CNT_W'(1);
      pos        = cnt_n - dly;
      in_word    = launch && (cnt_n >= dly) && (pos < CNT_W'(len_eff));
      bit_idx    = IDX_W'(MAX_W - 1) - pos[IDX_W-1:0];
      chan_start = launch & start;
      chan_nxt   = start ? lr_lvl : ch_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
         lr_q  <= CH_RIGHT;
         wck_q <= 1'b0;
         ch_q  <= CH_RIGHT;
      end else if (launch) begin
         cnt_q <= cnt_n;
         lr_q  <= lr_lvl;
         wck_q <= wck_lvl;
         ch_q  <= chan_nxt;
      end
   end

endmodule

// File: rtl/astx_shifter.sv
module astx_shifter #(
   parameter int MAX_W  = 24,
   localparam int IDX_W = $clog2(MAX_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [1:0][MAX_W-1:0] samp_in,
   input  logic                  frame_start,
   input  logic                  launch,
   input  logic                  in_word,
   input  logic                  chan_sel,
   input  logic [IDX_W-1:0]      bit_idx,
   output logic                  sdata
);

   logic [1:0] ch_bit;

   for (genvar c = 0; c < 2; c++) begin : g_chan
      logic [MAX_W-1:0] hold_q, act_q, src;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
            act_q  <= '0;
         end else begin
            if (load)        hold_q <= samp_in[c];
            if (frame_start) act_q  <= hold_q;
         end
      end

      assign src       = frame_start ? hold_q : act_q;
      assign ch_bit[c] = src[bit_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sdata <= 1'b0;
      else if (launch) sdata <= in_word ? ch_bit[chan_sel] : 1'b0;
   end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
   import astx_pkg::*;
#(
   parameter int MAX_W    = 24,
   parameter int MIN_W    = 4,
   parameter int RJ_OFS   = 16,
   parameter int SYNC_STG = 2,
   localparam int LEN_W   = $clog2(MAX_W + 1),
   localparam int IDX_W   = $clog2(MAX_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_clk,
   input  logic             lr_clk,
   input  logic             word_clk,
   input  logic             samp_pol,
   input  logic [1:0]       fmt_sel,
   input  logic [LEN_W-1:0] word_len,
   input  logic             load,
   input  logic [MAX_W-1:0] left_in,
   input  logic [MAX_W-1:0] right_in,
   output logic             sdata_out
);

   generate
      if (MIN_W < 1 || MAX_W < MIN_W) begin : g_bad_width
         $error("audio_ser_tx: need 1 <= MIN_W <= MAX_W");
      end
      if (RJ_OFS < 1) begin : g_bad_ofs
         $error("audio_ser_tx: RJ_OFS must be positive");
      end
   endgenerate

   logic             bclk_lvl, bclk_d, lr_lvl, wck_lvl, launch;
   logic             chan_start, chan_nxt, in_word, frame_start;
   logic [IDX_W-1:0] bit_idx;
   logic [LEN_W-1:0] len_eff;

   astx_sync #(.STAGES(SYNC_STG)) u_sync_bclk (
      .clk(clk), .rst_n(rst_n), .d_in(bit_clk), .lvl(bclk_lvl));
   astx_sync #(.STAGES(SYNC_STG)) u_sync_lr (
      .clk(clk), .rst_n(rst_n), .d_in(lr_clk), .lvl(lr_lvl));
   astx_sync #(.STAGES(SYNC_STG)) u_sync_wck (
      .clk(clk), .rst_n(rst_n), .d_in(word_clk), .lvl(wck_lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= bclk_lvl;
   end

   // data launches on the edge opposite the receiver's sampling edge
   assign launch = samp_pol ? (bclk_lvl & ~bclk_d) : (~bclk_lvl & bclk_d);

   always_comb begin
      if (word_len < LEN_W'(MIN_W))      len_eff = LEN_W'(MIN_W);
      else if (word_len > LEN_W'(MAX_W)) len_eff = LEN_W'(MAX_W);
      else                               len_eff = word_len;
   end

   astx_framer #(.MAX_W(MAX_W), .RJ_OFS(RJ_OFS)) u_framer (
      .clk(clk), .rst_n(rst_n), .launch(launch),
      .fmt(astx_fmt_e'(fmt_sel)), .lr_lvl(lr_lvl), .wck_lvl(wck_lvl),
      .len_eff(len_eff), .chan_start(chan_start), .chan_nxt(chan_nxt),
      .in_word(in_word), .bit_idx(bit_idx));

   assign frame_start = chan_start & (chan_nxt == CH_LEFT);

   astx_shifter #(.MAX_W(MAX_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .load(load),
      .samp_in({right_in, left_in}), .frame_start(frame_start),
      .launch(launch), .in_word(in_word), .chan_sel(chan_nxt),
      .bit_idx(bit_idx), .sdata(sdata_out));

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
   parameter int MAX_W = 24
) (
   input logic clk,
   input logic rst_n,
   input logic sdata_out,
   input logic launch,
   input logic in_word,
   input logic chan_start
);

   logic [7:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else if (launch) begin
         if (!in_word)            run_q <= '0;
         else if (chan_start)     run_q <= 8'd1;
         else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
      end
   end

   assert_rst_low_R10: assert property (@(posedge clk)
      !rst_n |=> !sdata_out);

   assert_edge_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdata_out) |-> $past(launch));

   assert_tail_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !in_word) |=> !sdata_out);

   assert_len_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= 8'(MAX_W));

endmodule

bind audio_ser_tx audio_ser_tx_chk #(.MAX_W(MAX_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .sdata_out(sdata_out),
   .launch(launch), .in_word(in_word), .chan_start(chan_start));

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_clk = 1'b1, lr_clk = 1'b1, word_clk = 1'b0, samp_pol = 1'b0;
   logic        load = 1'b0;
   logic [1:0]  fmt_sel = 2'd0;
   logic [4:0]  word_len = 5'd24;
   logic [23:0] left_in = '0, right_in = '0;
   logic        sdata_out;

   int          n_chk = 0, n_err = 0;
   bit          done = 1'b0;
   bit          exp_q[$];
   string       tag_q[$];
   event        smp_ev;
   logic [23:0] hl = '0, hr = '0;

   always #4 clk = ~clk;

   audio_ser_tx i_audio_ser_tx (
      .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .lr_clk(lr_clk),
      .word_clk(word_clk), .samp_pol(samp_pol), .fmt_sel(fmt_sel),
      .word_len(word_len), .load(load), .left_in(left_in),
      .right_in(right_in), .sdata_out(sdata_out));

   task automatic chk(bit act, bit exp, string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: sdata_out=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: pops one expected bit per receiver sampling instant
   initial forever begin
      @(smp_ev);
      if (exp_q.size() == 0) begin
         n_chk++; n_err++;
         $display("FAIL scoreboard: no expected bit queued, actual %0b expected none", sdata_out);
      end else begin
         chk(sdata_out, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   function automatic int eff_len(int l);
      return (l < 4) ? 4 : (l > 24) ? 24 : l;
   endfunction

   task automatic load_pair(logic [23:0] l, logic [23:0] r);
      @(negedge clk);
      left_in = l; right_in = r; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      hl = l; hr = r;
   endtask

   task automatic bit_cyc(bit lv, bit wv, int gap);
      @(negedge clk);
      lr_clk = lv; word_clk = wv; bit_clk = samp_pol;   // launching transition
      repeat (4) @(negedge clk);
      -> smp_ev;
      bit_clk = ~samp_pol;                              // sampling transition
      repeat (3 + gap) @(negedge clk);
   endtask

   task automatic send_chan(bit lvl, logic [23:0] s, int mode, int leff, int nclk,
                            int gap_every, string tag, bit mid, logic [23:0] ml,
                            logic [23:0] mr);
      int d;
      d = (mode == 1) ? 1 : (mode == 2) ? 16 : 0;
      for (int k = 0; k < nclk; k++) begin
         int p;
         bit e;
         p = k - d;
         e = (p >= 0 && p < leff) ? s[23-p] : 1'b0;
         exp_q.push_back(e);
         tag_q.push_back(tag);
         bit_cyc((mode == 3 && k == 5) ? ~lvl : lvl,
                 (k == 0) || (mode != 3 && k == 5),
                 (gap_every > 0 && (k % gap_every) == 2) ? 25 : 0);
         if (mid && k == 8) load_pair(ml, mr);
      end
   endtask

   task automatic send_frame(int mode, int len_in, int nclk, int gap_every, string tag,
                             bit mid, logic [23:0] ml, logic [23:0] mr);
      logic [23:0] fl, fr;
      @(negedge clk);
      fmt_sel = 2'(mode); word_len = 5'(len_in);
      fl = hl; fr = hr;
      send_chan(1'b0, fl, mode, eff_len(len_in), nclk, gap_every, tag, mid, ml, mr);
      send_chan(1'b1, fr, mode, eff_len(len_in), nclk, gap_every, tag, 1'b0, ml, mr);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: run incomplete, actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(sdata_out, 1'b0, "R10 reset state");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R8: no channel start yet, line stays low
      send_chan(1'b1, 24'h0, 0, 24, 8, 0, "R8 before first start", 1'b0, '0, '0);
      // R10: holding registers cleared, first frame sends zeros
      send_frame(0, 24, 32, 0, "R10 cleared hold", 1'b0, '0, '0);
      // R1 R3: left-justified, full length
      load_pair(24'hA53C96, 24'h3F0E71);
      send_frame(0, 24, 32, 0, "R1 R3 left-justified", 1'b0, '0, '0);
      // R9 R8: no load -> repeat, shorter word with low tail
      send_frame(0, 16, 24, 0, "R9 R8 repeat and tail", 1'b0, '0, '0);
      // R4: one-bit delay
      load_pair(24'h817E55, 24'hC3A5F0);
      send_frame(1, 20, 32, 0, "R4 delayed MSB", 1'b0, '0, '0);
      // R5: 16-slot offset
      load_pair(24'h6D2B9E, 24'hF00F5A);
      send_frame(2, 16, 32, 0, "R5 offset len16", 1'b0, '0, '0);
      send_frame(2, 24, 40, 0, "R5 offset len24", 1'b0, '0, '0);
      // R6: word-clock framing with an lr glitch mid-word
      load_pair(24'h93C6E1, 24'h2A54A9);
      send_frame(3, 24, 32, 0, "R6 word clock mode", 1'b0, '0, '0);
      // R9: load during the left channel applies only from the next frame
      send_frame(0, 24, 32, 0, "R9 mid-frame load", 1'b1, 24'h5EC3B7, 24'hB1D24F);
      send_frame(0, 24, 32, 0, "R9 next frame after load", 1'b0, '0, '0);
      // R2: clamping of word length
      send_frame(0, 2, 16, 0, "R2 clamp to 4", 1'b0, '0, '0);
      send_frame(0, 30, 32, 0, "R2 clamp to 24", 1'b0, '0, '0);
      // R7 R11: reversed polarity with a bursty bit clock
      @(negedge clk);
      samp_pol = 1'b1;
      @(negedge clk);
      bit_clk = 1'b0;
      repeat (6) @(negedge clk);
      load_pair(24'h7C18E3, 24'h0F96A5);
      send_frame(0, 24, 32, 4, "R7 R11 inverted bursty", 1'b0, '0, '0);
      send_frame(1, 18, 32, 3, "R7 R11 inverted delayed", 1'b0, '0, '0);
      // R10: mid-run reset clears holding pair
      load_pair(24'hFFFFFF, 24'hFFFFFF);
      @(negedge clk);
      rst_n = 1'b0;
      hl = '0; hr = '0;
      repeat (3) @(negedge clk);
      chk(sdata_out, 1'b0, "R10 line low in reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      send_chan(1'b1, 24'h0, 0, 24, 8, 0, "R10 idle after reset", 1'b0, '0, '0);
      send_frame(0, 24, 32, 0, "R10 hold cleared by reset", 1'b0, '0, '0);
      load_pair(24'hD4A1C7, 24'h39E65B);
      send_frame(3, 12, 32, 0, "R6 R1 word clock short word", 1'b0, '0, '0);
      repeat (10) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule